// File: doc/BRIEF.md
# Cycle and Event Counter Unit

This block measures execution activity inside a processor subsystem. It holds one free-running cycle counter and four event counters, all 32 bits wide. Each event counter is fed by a single-cycle pulse line. Software programs the unit through a small register port. Writes take effect at the next clock edge. Reads are combinational from the current register state.

A control register carries the master enable, two self-clearing reset commands and a divide-by-64 option for the cycle counter. Per-counter enables and per-counter interrupt enables each have a set register and a clear register. Wraps are recorded in a write-one-to-clear status register. The interrupt output goes high when any recorded wrap has its interrupt enabled. A single stored bit is exposed on a pin so that surrounding logic can decide whether unprivileged code may read the counters.

The counter registers are also writable. This lets software preload a value, for example just below the wrap point.

Top module: `pmu_unit`

Register addresses, 4-bit `addr`: 0 control, 1 enable-set, 2 enable-clear, 3 wrap status, 4 interrupt-enable-set, 5 interrupt-enable-clear, 6 user access, 7 cycle counter, 8 to 11 event counters 0 to 3. Addresses 12 to 15 are unmapped. In every per-counter mask, bit 31 is the cycle counter and bits 0 to 3 are event counters 0 to 3.

## Requirements
- R1: A counter advances only while control bit 0 (master enable) and its own enable bit are both 1. With either bit at 0, its value holds.
- R2: Writing control with bit 1 = 1 zeroes all event counters. Writing control with bit 2 = 1 zeroes the cycle counter and the divider phase. Both bits always read as 0. A reset takes priority over a simultaneous preload and over counting.
- R3: An enabled event counter adds exactly 1 for each clock cycle in which its event line is high.
- R4: With control bit 3 = 1, the cycle counter adds 1 once per 64 enabled clock cycles. The first step comes on the 64th enabled cycle after the divider phase is cleared. With bit 3 = 0, the cycle counter adds 1 on every enabled cycle.
- R5: Control bit 4 is stored and reads back. It has no effect on counting, wrap flags or the interrupt.
- R6: Writing 1 to a mask bit at address 1 sets that counter's enable. Writing 1 at address 2 clears it. Writing 0 bits changes nothing. Both addresses read back the current enable mask.
- R7: When a counter steps from 0xFFFFFFFF to 0, its bit in the wrap status register (address 3) becomes 1. Writing 1 to a status bit clears it, and writing 0 leaves it. If a wrap and a clear hit the same bit in the same cycle, the wrap wins.
- R8: Addresses 4 and 5 set and clear interrupt enables with the same mask layout. `irq` is high exactly when some status bit and its interrupt enable are both 1.
- R9: Address 6 bit 0 stores the user-access grant. It reads back and drives `user_access`.
- R10: A write to address 7 or to addresses 8 to 11 loads that counter with `wdata`. The load takes priority over counting in the same cycle. Reads of these addresses return the count. Unmapped addresses read 0.
- R11: After reset every register, counter, flag and output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| evt_in | input | 4 | Event pulse lines, one per event counter |
| irq | output | 1 | Wrap interrupt |
| user_access | output | 1 | Unprivileged read grant |

## Verification
The event lines are driven all-high, in alternating and shifting patterns, and all-low. This separates a counter that tracks its own line from one that counts cycles or picks up a neighbour's line. The cycle counter is run at full rate and with the divider. The divider phase is also cleared midway through a period, which shows whether the phase resets together with the count. Preloads just below the wrap point force wraps with the interrupt enable both on and off. A wrap is also made to coincide with a status clear, and a reset or preload is made to coincide with active events, which exercises every priority rule.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] REG_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] REG_EN_SET = 4'd1;
    localparam logic [ADDR_W-1:0] REG_EN_CLR = 4'd2;
    localparam logic [ADDR_W-1:0] REG_OVF    = 4'd3;
    localparam logic [ADDR_W-1:0] REG_IE_SET = 4'd4;
    localparam logic [ADDR_W-1:0] REG_IE_CLR = 4'd5;
    localparam logic [ADDR_W-1:0] REG_USER   = 4'd6;
    localparam logic [ADDR_W-1:0] REG_CYC    = 4'd7;
    localparam logic [ADDR_W-1:0] REG_EVT0   = 4'd8;

    // control bit positions
    localparam int CTL_GLOB    = 0;
    localparam int CTL_RST_EVT = 1;
    localparam int CTL_RST_CYC = 2;
    localparam int CTL_DIV     = 3;
    localparam int CTL_EXP     = 4;

    // mask bit that selects the cycle counter
    localparam int CYC_BIT = 31;
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         wrap
);
    // a wrap is only a real step from all-ones, not a clear or a load
    assign wrap = inc && !clr && !load && (&value);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else if (load) begin
            value <= load_val;
        end else if (inc) begin
            value <= value + W'(1);
        end
    end
endmodule

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
    parameter int LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    logic [LOG2-1:0] phase;

    assign tick = run && (&phase);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (clr) begin
            phase <= '0;
        end else if (run) begin
            phase <= phase + LOG2'(1);
        end
    end
endmodule

// File: rtl/pmu_unit.sv
module pmu_unit
    import pmu_pkg::*;
#(
    parameter int NUM_EVT  = 4,
    parameter int CNT_W    = 32,
    parameter int PRE_LOG2 = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               irq,
    output logic               user_access
);
    localparam int NC = NUM_EVT + 1;  // counters in total
    localparam int CI = NUM_EVT;      // internal index of the cycle counter

    logic              glob_en, div_en, exp_en, user_en;
    logic [NC-1:0]     cnt_en, ie, ovf, wrap, inc, load;
    logic [NC-1:0]     wmask, ovf_w1c;
    logic [CNT_W-1:0]  val [NC];
    logic              rst_evt, rst_cyc, cyc_run, pre_tick;

    assign wmask   = {wdata[CYC_BIT], wdata[NUM_EVT-1:0]};
    assign rst_evt = wr_en && (addr == REG_CTRL) && wdata[CTL_RST_EVT];
    assign rst_cyc = wr_en && (addr == REG_CTRL) && wdata[CTL_RST_CYC];
    assign ovf_w1c = (wr_en && (addr == REG_OVF)) ? wmask : '0;

    // event counters
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        assign inc[i]  = glob_en && cnt_en[i] && evt_in[i];
        assign load[i] = wr_en && (addr == ADDR_W'(int'(REG_EVT0) + i));
        pmu_counter #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (rst_evt),
            .load     (load[i]),
            .load_val (wdata[CNT_W-1:0]),
            .inc      (inc[i]),
            .value    (val[i]),
            .wrap     (wrap[i])
        );
    end

    // cycle counter with optional divider
    assign cyc_run  = glob_en && cnt_en[CI];
    assign inc[CI]  = cyc_run && (!div_en || pre_tick);
    assign load[CI] = wr_en && (addr == REG_CYC);

    pmu_prescaler #(.LOG2(PRE_LOG2)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rst_cyc),
        .run   (cyc_run && div_en),
        .tick  (pre_tick)
    );

    pmu_counter #(.W(CNT_W)) u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rst_cyc),
        .load     (load[CI]),
        .load_val (wdata[CNT_W-1:0]),
        .inc      (inc[CI]),
        .value    (val[CI]),
        .wrap     (wrap[CI])
    );

    // configuration and status registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glob_en <= 1'b0;
            div_en  <= 1'b0;
            exp_en  <= 1'b0;
            user_en <= 1'b0;
            cnt_en  <= '0;
            ie      <= '0;
            ovf     <= '0;
        end else begin
            if (wr_en) begin
                case (addr)
                    REG_CTRL: begin
                        glob_en <= wdata[CTL_GLOB];
                        div_en  <= wdata[CTL_DIV];
                        exp_en  <= wdata[CTL_EXP];
                    end
                    REG_EN_SET: cnt_en  <= cnt_en | wmask;
                    REG_EN_CLR: cnt_en  <= cnt_en & ~wmask;
                    REG_IE_SET: ie      <= ie | wmask;
                    REG_IE_CLR: ie      <= ie & ~wmask;
                    REG_USER:   user_en <= wdata[0];
                    default: ;
                endcase
            end
            ovf <= (ovf & ~ovf_w1c) | wrap;
        end
    end

    function automatic logic [DATA_W-1:0] to_bus(input logic [NC-1:0] m);
        logic [DATA_W-1:0] r;
        r = '0;
        r[CYC_BIT]       = m[CI];
        r[NUM_EVT-1:0]   = m[NUM_EVT-1:0];
        return r;
    endfunction

    always_comb begin
        rdata = '0;
        case (addr)
            REG_CTRL: begin
                rdata[CTL_GLOB] = glob_en;
                rdata[CTL_DIV]  = div_en;
                rdata[CTL_EXP]  = exp_en;
            end
            REG_EN_SET, REG_EN_CLR: rdata = to_bus(cnt_en);
            REG_OVF:                rdata = to_bus(ovf);
            REG_IE_SET, REG_IE_CLR: rdata = to_bus(ie);
            REG_USER:               rdata[0] = user_en;
            REG_CYC:                rdata = DATA_W'(val[CI]);
            default: ;
        endcase
        for (int i = 0; i < NUM_EVT; i++) begin
            if (addr == ADDR_W'(int'(REG_EVT0) + i)) rdata = DATA_W'(val[i]);
        end
    end

    assign irq         = |(ovf & ie);
    assign user_access = user_en;
endmodule

// File: rtl/pmu_unit_chk.sv
module pmu_unit_chk
    import pmu_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              user_access,
    input logic              glob_en,
    input logic              div_en,
    input logic              cyc_en,
    input logic [CNT_W-1:0]  cyc_val,
    input logic              cyc_ovf
);
    p_cyc_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_CTRL && wdata[CTL_RST_CYC]) |=> (cyc_val == '0));

    p_ctrl_rd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == REG_CTRL) |-> (rdata[CTL_RST_CYC:CTL_RST_EVT] == 2'b00));

    p_hold_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !wr_en) |=> $stable(cyc_val));

    p_full_rate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_en && cyc_en && !div_en && !wr_en) |=> (cyc_val == $past(cyc_val) + CNT_W'(1)));

    p_div_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_en && cyc_en && div_en && !wr_en) |=>
            (cyc_val == $past(cyc_val) || cyc_val == $past(cyc_val) + CNT_W'(1)));

    p_wrap_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_en && cyc_en && !div_en && !wr_en && (&cyc_val)) |=> cyc_ovf);

    p_user_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_USER) |=> (user_access == $past(wdata[0])));
endmodule

bind pmu_unit pmu_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .user_access (user_access),
    .glob_en     (glob_en),
    .div_en      (div_en),
    .cyc_en      (cnt_en[NUM_EVT]),
    .cyc_val     (val[NUM_EVT]),
    .cyc_ovf     (ovf[NUM_EVT])
);

// File: tb/pmu_unit_test.sv
`timescale 1ns/1ps
module pmu_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  evt_in = '0;
    logic [31:0] rdata;
    logic        irq, user_access;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pmu_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .evt_in(evt_in), .irq(irq), .user_access(user_access)
    );

    // behavioural reference state
    bit          m_glob, m_div, m_exp, m_user;
    logic [4:0]  m_en, m_ie, m_ov;   // bit 4 = cycle counter
    logic [31:0] m_cyc;
    logic [31:0] m_ev [4];
    int          m_pre;

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'd0: return {27'b0, m_exp, m_div, 2'b00, m_glob};
            4'd1, 4'd2: return {m_en[4], 27'b0, m_en[3:0]};
            4'd3: return {m_ov[4], 27'b0, m_ov[3:0]};
            4'd4, 4'd5: return {m_ie[4], 27'b0, m_ie[3:0]};
            4'd6: return {31'b0, m_user};
            4'd7: return m_cyc;
            4'd8, 4'd9, 4'd10, 4'd11: return m_ev[int'(a) - 8];
            default: return 32'h0;
        endcase
    endfunction

    task automatic m_update(input logic w, input logic [3:0] a, input logic [31:0] d, input logic [3:0] e);
        logic [4:0]  m;
        logic [4:0]  wraps;
        logic [31:0] n_cyc;
        logic [31:0] n_ev [4];
        int          n_pre;
        bit          ctl, run, tick;
        m = {d[31], d[3:0]};
        wraps = '0;
        ctl = w && (a == 4'd0);
        run = m_glob && m_en[4];
        tick = run && (!m_div || m_pre == 63);
        n_cyc = m_cyc;
        n_pre = m_pre;
        if (ctl && d[2]) begin
            n_cyc = 0;
            n_pre = 0;
        end else begin
            if (run && m_div) n_pre = (m_pre + 1) % 64;
            if (w && a == 4'd7) n_cyc = d;
            else if (tick) begin
                if (m_cyc == 32'hFFFF_FFFF) wraps[4] = 1'b1;
                n_cyc = m_cyc + 1;
            end
        end
        for (int i = 0; i < 4; i++) begin
            n_ev[i] = m_ev[i];
            if (ctl && d[1]) n_ev[i] = 0;
            else if (w && int'(a) == 8 + i) n_ev[i] = d;
            else if (m_glob && m_en[i] && e[i]) begin
                if (m_ev[i] == 32'hFFFF_FFFF) wraps[i] = 1'b1;
                n_ev[i] = m_ev[i] + 1;
            end
        end
        if (w && a == 4'd3) m_ov = m_ov & ~m;
        m_ov = m_ov | wraps;
        if (w) begin
            case (a)
                4'd0: begin m_glob = d[0]; m_div = d[3]; m_exp = d[4]; end
                4'd1: m_en = m_en | m;
                4'd2: m_en = m_en & ~m;
                4'd4: m_ie = m_ie | m;
                4'd5: m_ie = m_ie & ~m;
                4'd6: m_user = d[0];
                default: ;
            endcase
        end
        m_cyc = n_cyc;
        m_pre = n_pre;
        for (int i = 0; i < 4; i++) m_ev[i] = n_ev[i];
    endtask

    task automatic check(input string tag, input logic [3:0] a);
        logic [31:0] exp_rd;
        logic        exp_irq;
        exp_rd = m_read(a);
        exp_irq = |(m_ov & m_ie);
        n_cmp++;
        if (rdata !== exp_rd || irq !== exp_irq || user_access !== m_user) begin
            n_bad++;
            $display("FAIL %s addr=%0d rdata=%h/%h irq=%b/%b user=%b/%b (actual/expected)",
                     tag, a, rdata, exp_rd, irq, exp_irq, user_access, m_user);
        end
    endtask

    // drive at the falling edge, compare just after, then advance one clock
    task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d,
                        input logic [3:0] e, input string tag);
        wr_en = w; addr = a; wdata = d; evt_in = e;
        #1;
        check(tag, a);
        @(posedge clk);
        m_update(w, a, d, e);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
        step(1'b1, a, d, 4'h0, tag);
    endtask

    task automatic watch(input int n, input logic [3:0] a, input logic [3:0] e, input string tag);
        for (int k = 0; k < n; k++) step(1'b0, a, 32'h0, e, tag);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        m_glob = 0; m_div = 0; m_exp = 0; m_user = 0;
        m_en = '0; m_ie = '0; m_ov = '0; m_cyc = '0; m_pre = 0;
        for (int i = 0; i < 4; i++) m_ev[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: everything zero after reset
        for (int a = 0; a < 16; a++) step(1'b0, 4'(a), 32'h0, 4'hF, "R11");

        // R6 / R1: enables set but master off, no counting
        wr(4'd1, 32'h8000_000F, "R6");
        watch(5, 4'd8, 4'hF, "R1");
        watch(1, 4'd7, 4'h0, "R1");

        // R3: event patterns with master on
        wr(4'd0, 32'h1, "R1");
        watch(6, 4'd8, 4'hF, "R3");
        for (int k = 0; k < 8; k++) step(1'b0, 4'(8 + k % 4), 32'h0, (k % 2) ? 4'b1010 : 4'b0101, "R3");
        for (int k = 0; k < 8; k++) step(1'b0, 4'(8 + k % 4), 32'h0, 4'(4'b0011 << (k % 3)), "R3");
        watch(4, 4'd11, 4'h0, "R3");

        // R6: clearing enables
        wr(4'd2, 32'h0000_0005, "R6");
        for (int k = 0; k < 6; k++) step(1'b0, 4'(8 + k % 4), 32'h0, 4'hF, "R6");
        wr(4'd2, 32'h8000_0000, "R6");
        watch(3, 4'd7, 4'h0, "R6");
        watch(1, 4'd2, 4'h0, "R6");
        wr(4'd1, 32'h8000_0005, "R6");

        // R1: master off holds everything
        wr(4'd0, 32'h0, "R1");
        for (int k = 0; k < 6; k++) step(1'b0, 4'(7 + k % 5), 32'h0, 4'hF, "R1");

        // R4: divider, then phase cleared midway
        wr(4'd0, 32'h0000_000D, "R4");
        watch(140, 4'd7, 4'h0, "R4");
        watch(30, 4'd7, 4'h0, "R4");
        wr(4'd0, 32'h0000_000D, "R4");
        watch(70, 4'd7, 4'h0, "R4");

        // R5: export bit stored, no effect
        wr(4'd0, 32'h0000_0011, "R5");
        watch(2, 4'd0, 4'h0, "R5");
        watch(5, 4'd7, 4'h1, "R5");

        // R7 / R8: cycle counter wrap and interrupt
        wr(4'd7, 32'hFFFF_FFFD, "R10");
        watch(5, 4'd3, 4'h0, "R7");
        wr(4'd4, 32'h8000_0000, "R8");
        watch(2, 4'd4, 4'h0, "R8");
        wr(4'd3, 32'h0000_0000, "R7");
        watch(1, 4'd3, 4'h0, "R7");
        wr(4'd3, 32'h8000_0000, "R7");
        watch(2, 4'd3, 4'h0, "R7");

        // R7 / R8: event wrap, interrupt enable on and off
        wr(4'd8, 32'hFFFF_FFFF, "R10");
        step(1'b0, 4'd3, 32'h0, 4'h1, "R7");
        watch(2, 4'd3, 4'h0, "R8");
        wr(4'd4, 32'h0000_0001, "R8");
        watch(2, 4'd3, 4'h0, "R8");
        wr(4'd5, 32'h0000_0001, "R8");
        watch(2, 4'd5, 4'h0, "R8");
        // wrap and clear on the same bit: wrap wins
        wr(4'd4, 32'h0000_0001, "R8");
        wr(4'd8, 32'hFFFF_FFFF, "R7");
        step(1'b1, 4'd3, 32'h0000_0001, 4'h1, "R7");
        watch(2, 4'd3, 4'h0, "R7");
        wr(4'd3, 32'h8000_000F, "R7");
        watch(1, 4'd3, 4'h0, "R7");

        // R2: reset beats counting
        wr(4'd8, 32'd100, "R10");
        step(1'b1, 4'd0, 32'h0000_0007, 4'hF, "R2");
        for (int a = 7; a < 12; a++) step(1'b0, 4'(a), 32'h0, 4'h0, "R2");
        watch(1, 4'd0, 4'h0, "R2");
        watch(4, 4'd10, 4'hF, "R2");
        step(1'b1, 4'd0, 32'h0000_0003, 4'hF, "R2");
        watch(2, 4'd10, 4'h0, "R2");

        // R10: preload beats counting
        wr(4'd1, 32'h0000_0002, "R10");
        step(1'b1, 4'd9, 32'h0000_0055, 4'hF, "R10");
        watch(3, 4'd9, 4'hF, "R10");

        // R9: user access grant
        wr(4'd6, 32'h1, "R9");
        watch(2, 4'd6, 4'h0, "R9");
        wr(4'd6, 32'hFFFF_FFFE, "R9");
        watch(1, 4'd6, 4'h0, "R9");

        // R10: unmapped addresses
        for (int a = 12; a < 16; a++) step(1'b0, 4'(a), 32'h0, 4'h0, "R10");

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end
endmodule